// File: doc/BRIEF.md
# Decoded-Op Cache Fill Controller

The block sits behind the legacy instruction decoder. It takes the decoded instructions of one 32-byte code window, in the order they execute, and packs their micro-ops into ways of the set that the window indexes. Each way it fills is written out through a single way-write port. The write carries the window tag, the set index, the way number, the start byte offset of the way, the number of instruction bytes the way covers, the number of valid micro-op slots, and for each slot the offset of the instruction it belongs to plus a flag for the first slot of each instruction. Every way holds one contiguous run of instruction bytes.

A window may occupy at most three ways of its set. If it needs a fourth, the controller gives up on that window. It sends one invalidate command with a mask of the ways it has already written for the window, and ignores the rest of the window. An unconditional jump or a call ends the current way. A microcoded instruction takes a way for itself. The fill ends on a commit input, which marks the end of a window or a taken branch. A flush input abandons the fill. Victim ways come from a tree pseudo-LRU kept for each set.

Top module: `ucf_fill`

## Requirements
- R1: After reset, neither `wr_en` nor `inv_en` is asserted, and every set's pseudo-LRU state is cleared, so the first way that any set allocates is way 0.
- R2: An instruction whose micro-op count fits in the free slots of the open, unsealed way is appended to it. When a way closes, it is written in the cycle after the closing event with its start offset (the offset of its first instruction), its byte length (the sum of its instruction lengths) and its slot count.
- R3: If the open way has fewer free slots than the micro-op count of the incoming instruction, that way is written and a new way is opened for the instruction.
- R4: An instruction flagged as an unconditional jump or a call seals its way. The next instruction goes to a new way, and the sealed way is written when that instruction arrives or on commit.
- R5: A microcoded instruction always opens a new way of its own, writing any open way first, and seals that new way.
- R6: A window holds at most 3 ways (18 micro-ops at 6 slots per way). An instruction that would need a fourth way causes no write. Instead it issues an invalidate with `inv_mask` holding a 1 at bit w for every way w already written for the window. Further instructions are ignored until commit or flush.
- R7: `commit` writes the open way, if there is one, and ends the fill. If commit and an instruction arrive in the same cycle, commit takes priority and the instruction is dropped.
- R8: `flush` never writes the open way. It invalidates the ways already written for the window, if there are any, and returns the controller to idle. Flush takes priority over commit and instructions.
- R9: Victim ways come from a 7-bit tree pseudo-LRU per set. Allocation updates the tree so that it points away from the allocated way, and ways already held by the current window are excluded from the choice. On a fresh set, successive allocations yield the ways 0, 4, 2, 6, 1, 5, 3, 7 in that order, and each set is tracked independently.
- R10: `wr_first` bit s is set when slot s holds the first micro-op of an instruction. Field s of `wr_soff` (bits s*5 to s*5+4) holds that instruction's start offset. Unused slots read 0.
- R11: An instruction that runs past the end of its 32-byte window is stored under the window holding its start. It keeps its start offset and its full byte length.
- R12: A write and an invalidate are never issued in the same cycle, and both appear exactly one cycle after the input that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Decoded instruction valid |
| in_tag | input | TAG_W | Tag of the instruction's window |
| in_idx | input | IDX_W | Set index of the instruction's window |
| in_off | input | OFF_W | Start byte offset within the window |
| in_len | input | LEN_W | Instruction length in bytes |
| in_nuop | input | CNT_W | Micro-op count (1 to SLOTS) |
| in_ucode | input | 1 | Instruction is microcoded |
| in_jmp | input | 1 | Instruction is an unconditional jump |
| in_call | input | 1 | Instruction is a call |
| commit | input | 1 | End of window or taken branch: finish the fill |
| flush | input | 1 | Abandon the pending fill |
| wr_en | output | 1 | Way write strobe |
| wr_idx | output | IDX_W | Set written |
| wr_way | output | WAY_W | Way written |
| wr_tag | output | TAG_W | Tag stored in the way |
| wr_start | output | OFF_W | Start offset of the way's byte block |
| wr_len | output | LEN_W | Bytes covered by the way |
| wr_cnt | output | CNT_W | Valid micro-op slots |
| wr_first | output | SLOTS | Per-slot first-micro-op flag |
| wr_soff | output | SLOTS*OFF_W | Per-slot instruction start offset |
| inv_en | output | 1 | Invalidate strobe |
| inv_idx | output | IDX_W | Set to invalidate |
| inv_mask | output | WAYS | Ways to invalidate |

## Verification
The packing logic is driven with runs of small instructions that fill a way exactly, with runs that leave too few slots, and with jump, call and microcoded instructions placed both first in a way and after other instructions. This separates closure caused by slot count from closure caused by sealing. One window fills exactly three full ways, and another needs a fourth. Together they pin the three-way limit to an exact count and confirm that only ways actually written show up in the invalidate mask. Flushes are issued with no ways written and with one way written, and an instruction is sent after an overflow. These show that dropped data never reaches the write port. The victim order is followed through a full cycle of one set and then compared with a second set and with a reset in the middle of a fill.

// File: rtl/ucf_pkg.sv
package ucf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_DROP = 2'd2
  } fill_st_e;
endpackage

// File: rtl/ucf_plru.sv
// Per-set tree pseudo-LRU with exclusion mask on the victim walk.
module ucf_plru #(
  parameter int SETS = 32,
  parameter int WAYS = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [WAYS-1:0]  excl,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);
  logic [WAYS-2:0] tree_q [SETS];
  logic [WAYS-2:0] cur_t;
  logic [WAYS-2:0] next_t;

  assign cur_t = tree_q[rd_idx];

  // Walk: node bit 1 means the older side is the right subtree.
  always_comb begin
    int node, base, span;
    logic lf, rf, dir;
    node = 0;
    base = 0;
    span = WAYS;
    for (int l = 0; l < WAY_W; l++) begin
      span = span / 2;
      lf = 1'b0;
      rf = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if (!excl[w]) begin
          if (w >= base && w < base + span) lf = 1'b1;
          if (w >= base + span && w < base + 2 * span) rf = 1'b1;
        end
      end
      dir = cur_t[node];
      if (dir && !rf) dir = 1'b0;
      else if (!dir && !lf) dir = 1'b1;
      if (dir) base = base + span;
      node = 2 * node + 1 + int'(dir);
    end
    victim = base[WAY_W-1:0];
  end

  // Update: every node on the path points away from the touched way.
  always_comb begin
    int node;
    logic dir;
    next_t = cur_t;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      dir = touch_way[WAY_W-1-l];
      next_t[node] = ~dir;
      node = 2 * node + 1 + int'(dir);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[rd_idx] <= next_t;
    end
  end
endmodule

// File: rtl/ucf_way_buf.sv
// Staging buffer for the way currently being packed.
module ucf_way_buf #(
  parameter int SLOTS = 6,
  parameter int OFF_W = 5,
  parameter int LEN_W = 7,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_new,
  input  logic                   ld_app,
  input  logic [OFF_W-1:0]       in_off,
  input  logic [LEN_W-1:0]       in_len,
  input  logic [CNT_W-1:0]       in_nuop,
  output logic [CNT_W-1:0]       cnt,
  output logic [OFF_W-1:0]       start,
  output logic [LEN_W-1:0]       len,
  output logic [SLOTS-1:0]       first,
  output logic [SLOTS*OFF_W-1:0] soff
);
  logic [SLOTS-1:0]       first_n;
  logic [SLOTS*OFF_W-1:0] soff_n;

  always_comb begin
    int b;
    b = ld_new ? 0 : int'(cnt);
    first_n = ld_new ? '0 : first;
    soff_n  = ld_new ? '0 : soff;
    for (int s = 0; s < SLOTS; s++) begin
      if (s >= b && s < b + int'(in_nuop)) begin
        soff_n[s*OFF_W +: OFF_W] = in_off;
        first_n[s] = (s == b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      start <= '0;
      len   <= '0;
      first <= '0;
      soff  <= '0;
    end else if (ld_new || ld_app) begin
      cnt   <= ld_new ? in_nuop : cnt + in_nuop;
      start <= ld_new ? in_off : start;
      len   <= ld_new ? in_len : len + in_len;
      first <= first_n;
      soff  <= soff_n;
    end
  end
endmodule

// File: rtl/ucf_fill.sv
module ucf_fill #(
  parameter int SETS     = 32,
  parameter int WAYS     = 8,
  parameter int SLOTS    = 6,
  parameter int MAX_WAYS = 3,
  parameter int TAG_W    = 20,
  parameter int OFF_W    = 5,
  parameter int LEN_W    = 7,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int USE_W = $clog2(MAX_WAYS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_vld,
  input  logic [TAG_W-1:0]       in_tag,
  input  logic [IDX_W-1:0]       in_idx,
  input  logic [OFF_W-1:0]       in_off,
  input  logic [LEN_W-1:0]       in_len,
  input  logic [CNT_W-1:0]       in_nuop,
  input  logic                   in_ucode,
  input  logic                   in_jmp,
  input  logic                   in_call,
  input  logic                   commit,
  input  logic                   flush,
  output logic                   wr_en,
  output logic [IDX_W-1:0]       wr_idx,
  output logic [WAY_W-1:0]       wr_way,
  output logic [TAG_W-1:0]       wr_tag,
  output logic [OFF_W-1:0]       wr_start,
  output logic [LEN_W-1:0]       wr_len,
  output logic [CNT_W-1:0]       wr_cnt,
  output logic [SLOTS-1:0]       wr_first,
  output logic [SLOTS*OFF_W-1:0] wr_soff,
  output logic                   inv_en,
  output logic [IDX_W-1:0]       inv_idx,
  output logic [WAYS-1:0]        inv_mask
);
  import ucf_pkg::*;

  fill_st_e          st_q, st_n;
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              open_q, open_n, seal_q, seal_n;
  logic [WAY_W-1:0]  way_q, way_n;
  logic [USE_W-1:0]  used_q, used_n;
  logic [WAYS-1:0]   done_q, done_n, held_q, held_n;

  logic              wr_go, inv_go, buf_new, buf_app, touch;
  logic [WAYS-1:0]   inv_m;
  logic [IDX_W-1:0]  rd_idx;
  logic [WAY_W-1:0]  victim;
  logic [CNT_W-1:0]  b_cnt, free;
  logic [OFF_W-1:0]  b_start;
  logic [LEN_W-1:0]  b_len;
  logic [SLOTS-1:0]  b_first;
  logic [SLOTS*OFF_W-1:0] b_soff;
  logic              need_new;

  assign rd_idx = (st_q == FS_IDLE) ? in_idx : idx_q;
  assign free   = CNT_W'(SLOTS) - b_cnt;

  ucf_plru #(.SETS(SETS), .WAYS(WAYS)) plru_i (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .excl(held_q),
    .touch_en(touch), .touch_way(victim), .victim(victim)
  );

  ucf_way_buf #(.SLOTS(SLOTS), .OFF_W(OFF_W), .LEN_W(LEN_W)) buf_i (
    .clk(clk), .rst(rst), .ld_new(buf_new), .ld_app(buf_app),
    .in_off(in_off), .in_len(in_len), .in_nuop(in_nuop),
    .cnt(b_cnt), .start(b_start), .len(b_len), .first(b_first), .soff(b_soff)
  );

  always_comb begin
    st_n = st_q;  tag_n = tag_q;  idx_n = idx_q;
    open_n = open_q;  seal_n = seal_q;  way_n = way_q;
    used_n = used_q;  done_n = done_q;  held_n = held_q;
    wr_go = 1'b0;  inv_go = 1'b0;  inv_m = '0;
    buf_new = 1'b0;  buf_app = 1'b0;  touch = 1'b0;
    need_new = !open_q || seal_q || in_ucode || (free < in_nuop);
    if (flush) begin
      if (st_q != FS_IDLE && |done_q) begin
        inv_go = 1'b1;
        inv_m  = done_q;
      end
      st_n = FS_IDLE;
    end else if (commit) begin
      if (st_q == FS_FILL && open_q) wr_go = 1'b1;
      st_n = FS_IDLE;
    end else if (in_vld && st_q != FS_DROP) begin
      if (st_q == FS_IDLE) begin
        tag_n = in_tag;
        idx_n = in_idx;
        st_n  = FS_FILL;
      end
      if (need_new && used_q == USE_W'(MAX_WAYS)) begin
        if (|done_q) begin
          inv_go = 1'b1;
          inv_m  = done_q;
        end
        st_n   = FS_DROP;
        open_n = 1'b0;
        done_n = '0;
      end else if (need_new) begin
        if (open_q) begin
          wr_go  = 1'b1;
          done_n = done_q | (WAYS'(1) << way_q);
        end
        buf_new = 1'b1;
        touch   = 1'b1;
        way_n   = victim;
        held_n  = held_q | (WAYS'(1) << victim);
        used_n  = used_q + 1'b1;
        open_n  = 1'b1;
        seal_n  = in_jmp | in_call | in_ucode;
      end else begin
        buf_app = 1'b1;
        seal_n  = in_jmp | in_call;
      end
    end
    if (st_n == FS_IDLE) begin
      open_n = 1'b0;  seal_n = 1'b0;  used_n = '0;
      done_n = '0;    held_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= FS_IDLE;  tag_q <= '0;  idx_q <= '0;
      open_q <= 1'b0;  seal_q <= 1'b0;  way_q <= '0;
      used_q <= '0;  done_q <= '0;  held_q <= '0;
      wr_en <= 1'b0;  inv_en <= 1'b0;
    end else begin
      st_q <= st_n;  tag_q <= tag_n;  idx_q <= idx_n;
      open_q <= open_n;  seal_q <= seal_n;  way_q <= way_n;
      used_q <= used_n;  done_q <= done_n;  held_q <= held_n;
      wr_en <= wr_go;  inv_en <= inv_go;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      wr_idx   <= idx_q;   wr_way   <= way_q;   wr_tag  <= tag_q;
      wr_start <= b_start; wr_len   <= b_len;   wr_cnt  <= b_cnt;
      wr_first <= b_first; wr_soff  <= b_soff;
    end
    if (inv_go) begin
      inv_idx  <= idx_q;
      inv_mask <= inv_m;
    end
  end
endmodule

// File: rtl/ucf_fill_chk.sv
module ucf_fill_chk #(
  parameter int WAYS     = 8,
  parameter int SLOTS    = 6,
  parameter int MAX_WAYS = 3,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_cnt,
  input logic [SLOTS-1:0] wr_first,
  input logic             inv_en,
  input logic [WAYS-1:0]  inv_mask
);
  // R1: reset leaves no command pending
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!wr_en && !inv_en));

  // R12: write and invalidate are exclusive
  a_r12_one_cmd: assert property (@(posedge clk) disable iff (rst) !(wr_en && inv_en));

  // R2: a written way holds between 1 and SLOTS micro-ops
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_cnt >= CNT_W'(1) && wr_cnt <= CNT_W'(SLOTS)));

  // R6: an invalidate names between one and MAX_WAYS-1 written ways
  a_r6_inv_count: assert property (@(posedge clk) disable iff (rst)
    inv_en |-> ($countones(inv_mask) >= 1 && $countones(inv_mask) <= MAX_WAYS - 1));

  // R8: flush never lets the open way be written
  a_r8_flush_no_wr: assert property (@(posedge clk) disable iff (rst) flush |=> !wr_en);

  // R10: slot 0 of any written way starts an instruction
  a_r10_slot0_first: assert property (@(posedge clk) disable iff (rst) wr_en |-> wr_first[0]);
endmodule

bind ucf_fill ucf_fill_chk #(.WAYS(WAYS), .SLOTS(SLOTS), .MAX_WAYS(MAX_WAYS)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_cnt(wr_cnt),
  .wr_first(wr_first), .inv_en(inv_en), .inv_mask(inv_mask)
);

// File: tb/ucf_fill_tb_top.sv
module ucf_fill_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;
  localparam logic [19:0] TAG_BASE = 20'h12300;

  typedef struct packed {
    logic [1:0] kind;   // 0 idle, 1 instr, 2 commit, 3 flush
    logic [4:0] idx;
    logic [4:0] off;
    logic [6:0] len;
    logic [2:0] n;
    logic       mc, jb, cl;
    logic       ew;
    logic [2:0] eway;
    logic [4:0] est;
    logic [6:0] elen;
    logic [2:0] ecnt;
    logic       einv;
    logic [7:0] emask;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    // window A, set 3: packing and slot-count closure
    '{2'd1,5'd3,5'd0,7'd4,3'd2,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd2},  // R2
    '{2'd1,5'd3,5'd4,7'd3,3'd3,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd2},
    '{2'd1,5'd3,5'd7,7'd2,3'd2,1'b0,1'b0,1'b0, 1'b1,3'd0,5'd0,7'd7,3'd5, 1'b0,8'h00, 4'd3},  // R3
    '{2'd1,5'd3,5'd9,7'd5,3'd1,1'b0,1'b1,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd4},
    '{2'd2,5'd3,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,3'd4,5'd7,7'd7,3'd3, 1'b0,8'h00, 4'd7},  // R7, R4
    // window B: microcode, call, overflow
    '{2'd1,5'd3,5'd0,7'd3,3'd1,1'b1,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd5},
    '{2'd1,5'd3,5'd3,7'd2,3'd2,1'b0,1'b0,1'b0, 1'b1,3'd2,5'd0,7'd3,3'd1, 1'b0,8'h00, 4'd5},  // R5
    '{2'd1,5'd3,5'd5,7'd1,3'd1,1'b0,1'b0,1'b1, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd4},
    '{2'd1,5'd3,5'd6,7'd2,3'd4,1'b0,1'b0,1'b0, 1'b1,3'd6,5'd3,7'd3,3'd3, 1'b0,8'h00, 4'd4},  // R4
    '{2'd1,5'd3,5'd8,7'd2,3'd3,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b1,8'h44, 4'd6},  // R6
    '{2'd1,5'd3,5'd10,7'd1,3'd1,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd6},
    '{2'd2,5'd3,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd6},
    // window C: flush with nothing written
    '{2'd1,5'd3,5'd20,7'd14,3'd2,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd8},
    '{2'd3,5'd3,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd8},  // R8
    // window D: full way, then flush with one way written
    '{2'd1,5'd3,5'd0,7'd4,3'd6,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd3},
    '{2'd1,5'd3,5'd4,7'd1,3'd1,1'b0,1'b0,1'b0, 1'b1,3'd3,5'd0,7'd4,3'd6, 1'b0,8'h00, 4'd3},
    '{2'd3,5'd3,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b1,8'h08, 4'd8},  // R8
    // window E: boundary-crossing instruction, PLRU wraps to way 0
    '{2'd1,5'd3,5'd30,7'd6,3'd1,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd11},
    '{2'd2,5'd3,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,3'd0,5'd30,7'd6,3'd1,1'b0,8'h00, 4'd11}, // R11, R9
    // window F: microcoded after an open way
    '{2'd1,5'd3,5'd0,7'd1,3'd1,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd5},
    '{2'd1,5'd3,5'd1,7'd3,3'd2,1'b1,1'b0,1'b0, 1'b1,3'd4,5'd0,7'd1,3'd1, 1'b0,8'h00, 4'd5},
    '{2'd2,5'd3,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,3'd2,5'd1,7'd3,3'd2, 1'b0,8'h00, 4'd5},
    // window G, set 9: exactly 18 micro-ops fit, fresh PLRU
    '{2'd1,5'd9,5'd0,7'd6,3'd6,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd9},
    '{2'd1,5'd9,5'd6,7'd6,3'd6,1'b0,1'b0,1'b0, 1'b1,3'd0,5'd0,7'd6,3'd6, 1'b0,8'h00, 4'd9},
    '{2'd1,5'd9,5'd12,7'd6,3'd6,1'b0,1'b0,1'b0,1'b1,3'd4,5'd6,7'd6,3'd6, 1'b0,8'h00, 4'd6},
    '{2'd2,5'd9,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,3'd2,5'd12,7'd6,3'd6,1'b0,8'h00, 4'd6},
    '{2'd0,5'd9,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0, 1'b0,3'd0,5'd0,7'd0,3'd0, 1'b0,8'h00, 4'd12}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0, in_ucode = 1'b0, in_jmp = 1'b0, in_call = 1'b0;
  logic commit = 1'b0, flush = 1'b0;
  logic [19:0] in_tag = '0;
  logic [4:0]  in_idx = '0, in_off = '0;
  logic [6:0]  in_len = '0;
  logic [2:0]  in_nuop = '0;
  logic        wr_en, inv_en;
  logic [4:0]  wr_idx, wr_start, inv_idx;
  logic [2:0]  wr_way, wr_cnt;
  logic [19:0] wr_tag;
  logic [6:0]  wr_len;
  logic [5:0]  wr_first;
  logic [29:0] wr_soff;
  logic [7:0]  inv_mask;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucf_fill dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_tag(in_tag), .in_idx(in_idx),
    .in_off(in_off), .in_len(in_len), .in_nuop(in_nuop), .in_ucode(in_ucode),
    .in_jmp(in_jmp), .in_call(in_call), .commit(commit), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_start(wr_start), .wr_len(wr_len), .wr_cnt(wr_cnt), .wr_first(wr_first),
    .wr_soff(wr_soff), .inv_en(inv_en), .inv_idx(inv_idx), .inv_mask(inv_mask)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_vld = (v.kind == 2'd1);
    commit = (v.kind == 2'd2);
    flush  = (v.kind == 2'd3);
    in_idx = v.idx;  in_tag = TAG_BASE + 20'(v.idx);
    in_off = v.off;  in_len = v.len;  in_nuop = v.n;
    in_ucode = v.mc; in_jmp = v.jb;   in_call = v.cl;
  endtask

  function automatic logic [79:0] pack_out(input logic we, input logic [4:0] ix,
      input logic [2:0] wy, input logic [19:0] tg, input logic [4:0] st,
      input logic [6:0] ln, input logic [2:0] ct, input logic ie, input logic [7:0] mk);
    return {we, we ? {ix, wy, tg, st, ln, ct} : 43'd0, ie, ie ? {ix, mk} : 13'd0};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [79:0] a, e;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check(!wr_en && !inv_en, "R1", "reset outputs", {78'd0, wr_en, inv_en}, 80'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      a = pack_out(wr_en, wr_en ? wr_idx : inv_idx, wr_way, wr_tag, wr_start,
                   wr_len, wr_cnt, inv_en, inv_mask);
      e = pack_out(VEC[i].ew, VEC[i].idx, VEC[i].eway, TAG_BASE + 20'(VEC[i].idx),
                   VEC[i].est, VEC[i].elen, VEC[i].ecnt, VEC[i].einv, VEC[i].emask);
      check(a == e, $sformatf("R%0d", VEC[i].rq), $sformatf("vector %0d", i), a, e);
      if (i == 2) begin
        // R10: slots 0-1 from offset 0, slots 2-4 from offset 4, slot 5 unused
        check(wr_first == 6'b000101, "R10", "first flags", 80'(wr_first), 80'(6'b000101));
        check(wr_soff == {5'd0, 5'd4, 5'd4, 5'd4, 5'd0, 5'd0}, "R10", "slot offsets",
              80'(wr_soff), 80'({5'd0, 5'd4, 5'd4, 5'd4, 5'd0, 5'd0}));
      end
    end

    // R1: reset in the middle of a fill drops it and restarts the PLRU of set 9
    drive('{2'd1,5'd9,5'd0,7'd2,3'd1,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0,1'b0,8'h00,4'd1});
    @(negedge clk);
    rst = 1'b1;
    drive('{2'd2,5'd9,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0,1'b0,8'h00,4'd1});
    @(negedge clk);
    @(negedge clk);
    check(!wr_en && !inv_en, "R1", "mid-fill reset", {78'd0, wr_en, inv_en}, 80'd0);
    rst = 1'b0;
    drive('{2'd1,5'd9,5'd3,7'd2,3'd1,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0,1'b0,8'h00,4'd1});
    @(negedge clk);
    drive('{2'd2,5'd9,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0,1'b0,8'h00,4'd1});
    @(negedge clk);
    a = pack_out(wr_en, wr_idx, wr_way, wr_tag, wr_start, wr_len, wr_cnt, inv_en, inv_mask);
    e = pack_out(1'b1, 5'd9, 3'd0, TAG_BASE + 20'd9, 5'd3, 7'd2, 3'd1, 1'b0, 8'h00);
    check(a == e, "R1", "first victim after reset", a, e);

    // R7: commit wins over a simultaneous instruction, which is dropped
    drive('{2'd1,5'd4,5'd0,7'd2,3'd1,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0,1'b0,8'h00,4'd7});
    @(negedge clk);
    drive('{2'd1,5'd4,5'd2,7'd3,3'd1,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0,1'b0,8'h00,4'd7});
    commit = 1'b1;
    @(negedge clk);
    a = pack_out(wr_en, wr_idx, wr_way, wr_tag, wr_start, wr_len, wr_cnt, inv_en, inv_mask);
    e = pack_out(1'b1, 5'd4, 3'd0, TAG_BASE + 20'd4, 5'd0, 7'd2, 3'd1, 1'b0, 8'h00);
    check(a == e, "R7", "commit with instruction", a, e);
    drive('{2'd0,5'd4,5'd0,7'd0,3'd0,1'b0,1'b0,1'b0,1'b0,3'd0,5'd0,7'd0,3'd0,1'b0,8'h00,4'd7});
    @(negedge clk);
    check(!wr_en && !inv_en, "R7", "idle after commit", {78'd0, wr_en, inv_en}, 80'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule